// File: doc/BRIEF.md
# Serial Port Loopback and Modem-Status Mirror

This block is the self-test path of a serial port controller. While loopback is on, it cuts the external receive side off from the receive buffer. Instead, it feeds the buffer with the words software writes for transmission, and with a break marker whenever software raises its send-break bit. It also copies the four software-driven modem-control outputs onto the modem-status flags through a fixed cross-mapping, and rebuilds the modem-status interrupt group from those flags.

While loopback is off, external characters and break events reach the receive buffer through the same push port. Control writes then leave the modem-status flags and interrupts alone.

Each push word is `DATA_W+1` bits wide. The top bit marks a break. A break word carries that bit set and all data bits zero. The buffer signals a full condition back on `rx_full_i`. A push that meets a full buffer is withheld.

Top module: `uart_lb_path`

## Requirements
- R1: A control write with the loopback bit set loads the ring-indicator flag (`ms_flags_o[3]`) from `out2` and the carrier-detect flag (`ms_flags_o[2]`) from `out1`. The new value is visible after the clock edge that registers the write.
- R2: On the same kind of write, the data-set-ready flag (`ms_flags_o[1]`) takes `dtr` and the clear-to-send flag (`ms_flags_o[0]`) takes `rts`.
- R3: Every control write loads the loopback state shown on `lb_active_o`. The mapping of R1 and R2 applies on the very write that turns loopback on.
- R4: On a loopback control write, `ms_irq_o` is rebuilt to equal the new flags exactly. This overrides any clear requested in the same cycle. Otherwise, each set bit of `ms_irq_clr_i` clears the matching bit of `ms_irq_o` on the next edge.
- R5: A control write with the loopback bit clear leaves `ms_flags_o` and `ms_irq_o` unchanged.
- R6: While loopback is active, a transmit write pushes `{1'b0, tx_data_i}` in the same cycle. While loopback is inactive, a transmit write pushes nothing.
- R7: While loopback is active, a rising edge of `brk_i` pushes the break word `{1'b1, '0}` in the same cycle. This takes priority over a transmit write in that cycle. A steady high `brk_i` pushes nothing further, and a rise while loopback is inactive pushes nothing.
- R8: While loopback is active, external characters and external break events push nothing.
- R9: While loopback is inactive, an external character pushes `{1'b0, data}` and an external break event pushes the break word. The break wins if both arrive in the same cycle.
- R10: While `rx_full_i` is high, no push is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_lbe_i | input | 1 | Loopback enable value being written |
| ctrl_out2_i | input | 1 | Software modem output 2 |
| ctrl_out1_i | input | 1 | Software modem output 1 |
| ctrl_dtr_i | input | 1 | Data-terminal-ready output |
| ctrl_rts_i | input | 1 | Request-to-send output |
| ms_irq_clr_i | input | 4 | Per-bit modem-status interrupt clear |
| brk_i | input | 1 | Send-break control bit (level) |
| tx_wr_i | input | 1 | Transmit data write strobe |
| tx_data_i | input | DATA_W | Transmit data |
| ext_rx_valid_i | input | 1 | External received character strobe |
| ext_rx_data_i | input | DATA_W | External received character |
| ext_brk_i | input | 1 | External break event strobe |
| rx_full_i | input | 1 | Receive buffer full |
| lb_active_o | output | 1 | Loopback state in effect |
| ms_flags_o | output | 4 | Modem-status flags {ri, dcd, dsr, cts} |
| ms_irq_o | output | 4 | Modem-status interrupt bits, same order |
| rx_push_o | output | 1 | Push strobe toward receive buffer |
| rx_push_data_o | output | DATA_W+1 | Push word, top bit marks break |

## Verification
Eight control writes are tried in turn. They mix the four outputs one at a time, all together, none at all, and interleaved with writes that have loopback off. This shows whether each flag follows its own cross-mapped source and whether non-loopback writes really hold state. The push path is tried with transmit words, external characters and break events in both modes. It is also tried with coincident break and data, with a held break level, and against a full buffer, which separates the source priority, edge detection and drop rules.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  localparam int MS_W = 4;

  typedef struct packed {
    logic ri;
    logic dcd;
    logic dsr;
    logic cts;
  } ms_vec_t;

  function automatic logic [MS_W-1:0] ms_map(input logic out2, input logic out1,
                                             input logic dtr, input logic rts);
    ms_vec_t v;
    v.ri  = out2;
    v.dcd = out1;
    v.dsr = dtr;
    v.cts = rts;
    return v;
  endfunction
endpackage

// File: rtl/lb_ms_mirror.sv
module lb_ms_mirror
  import uart_lb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            lbe_i,
  input  logic            out2_i,
  input  logic            out1_i,
  input  logic            dtr_i,
  input  logic            rts_i,
  input  logic [MS_W-1:0] irq_clr_i,
  output logic            lbe_q_o,
  output logic [MS_W-1:0] flags_o,
  output logic [MS_W-1:0] irq_o
);
  logic            rebuild;
  logic [MS_W-1:0] flags_d;

  assign rebuild = wr_i & lbe_i;
  assign flags_d = ms_map(out2_i, out1_i, dtr_i, rts_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lbe_q_o <= 1'b0;
      flags_o <= '0;
      irq_o   <= '0;
    end else begin
      if (wr_i) lbe_q_o <= lbe_i;
      if (rebuild) begin
        flags_o <= flags_d;
        // whole group cleared, then re-raised from the new flags
        irq_o   <= flags_d;
      end else begin
        irq_o   <= irq_o & ~irq_clr_i;
      end
    end
  end
endmodule

// File: rtl/lb_rx_sel.sv
module lb_rx_sel #(
  parameter int DATA_W = 8,
  localparam int PW = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lbe_i,
  input  logic              brk_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              ext_valid_i,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic              ext_brk_i,
  input  logic              full_i,
  output logic              push_o,
  output logic [PW-1:0]     push_data_o
);
  localparam logic [PW-1:0] BRK_WORD = {1'b1, {DATA_W{1'b0}}};

  logic brk_q;
  logic brk_rise;
  logic cand;
  logic [PW-1:0] cand_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_q <= 1'b0;
    else         brk_q <= brk_i;
  end

  assign brk_rise = brk_i & ~brk_q;

  always_comb begin
    cand      = 1'b0;
    cand_data = '0;
    if (lbe_i) begin
      if (brk_rise) begin
        cand      = 1'b1;
        cand_data = BRK_WORD;
      end else if (tx_wr_i) begin
        cand      = 1'b1;
        cand_data = {1'b0, tx_data_i};
      end
    end else begin
      if (ext_brk_i) begin
        cand      = 1'b1;
        cand_data = BRK_WORD;
      end else if (ext_valid_i) begin
        cand      = 1'b1;
        cand_data = {1'b0, ext_data_i};
      end
    end
  end

  assign push_o      = cand & ~full_i;
  assign push_data_o = cand_data;
endmodule

// File: rtl/uart_lb_path.sv
module uart_lb_path
  import uart_lb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_lbe_i,
  input  logic              ctrl_out2_i,
  input  logic              ctrl_out1_i,
  input  logic              ctrl_dtr_i,
  input  logic              ctrl_rts_i,
  input  logic [3:0]        ms_irq_clr_i,
  input  logic              brk_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              ext_rx_valid_i,
  input  logic [DATA_W-1:0] ext_rx_data_i,
  input  logic              ext_brk_i,
  input  logic              rx_full_i,
  output logic              lb_active_o,
  output logic [3:0]        ms_flags_o,
  output logic [3:0]        ms_irq_o,
  output logic              rx_push_o,
  output logic [DATA_W:0]   rx_push_data_o
);
  logic lbe_q;

  lb_ms_mirror u_mirror (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ctrl_wr_i),
    .lbe_i    (ctrl_lbe_i),
    .out2_i   (ctrl_out2_i),
    .out1_i   (ctrl_out1_i),
    .dtr_i    (ctrl_dtr_i),
    .rts_i    (ctrl_rts_i),
    .irq_clr_i(ms_irq_clr_i),
    .lbe_q_o  (lbe_q),
    .flags_o  (ms_flags_o),
    .irq_o    (ms_irq_o)
  );

  lb_rx_sel #(.DATA_W(DATA_W)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lbe_i      (lbe_q),
    .brk_i      (brk_i),
    .tx_wr_i    (tx_wr_i),
    .tx_data_i  (tx_data_i),
    .ext_valid_i(ext_rx_valid_i),
    .ext_data_i (ext_rx_data_i),
    .ext_brk_i  (ext_brk_i),
    .full_i     (rx_full_i),
    .push_o     (rx_push_o),
    .push_data_o(rx_push_data_o)
  );

  assign lb_active_o = lbe_q;
endmodule

// File: rtl/uart_lb_path_chk.sv
module uart_lb_path_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_wr_i,
  input logic              ctrl_lbe_i,
  input logic              ctrl_out2_i,
  input logic              ctrl_out1_i,
  input logic              ctrl_dtr_i,
  input logic              ctrl_rts_i,
  input logic              brk_i,
  input logic              tx_wr_i,
  input logic [DATA_W-1:0] tx_data_i,
  input logic              rx_full_i,
  input logic              lb_active_o,
  input logic [3:0]        ms_flags_o,
  input logic [3:0]        ms_irq_o,
  input logic              rx_push_o,
  input logic [DATA_W:0]   rx_push_data_o
);
  a_r1_ri_dcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_lbe_i |=> ms_flags_o[3:2] == {$past(ctrl_out2_i), $past(ctrl_out1_i)});

  a_r2_dsr_cts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_lbe_i |=> ms_flags_o[1:0] == {$past(ctrl_dtr_i), $past(ctrl_rts_i)});

  a_r3_lb_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> lb_active_o == $past(ctrl_lbe_i));

  a_r4_irq_rebuild: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_lbe_i |=> ms_irq_o == ms_flags_o);

  a_r5_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_wr_i && ctrl_lbe_i) |=> $stable(ms_flags_o));

  a_r6_tx_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_active_o && tx_wr_i && !brk_i && !rx_full_i |-> rx_push_o && rx_push_data_o == {1'b0, tx_data_i});

  a_r8_ext_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_active_o && !tx_wr_i && !brk_i |-> !rx_push_o);

  a_r10_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_i |-> !rx_push_o);
endmodule

bind uart_lb_path uart_lb_path_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctrl_wr_i     (ctrl_wr_i),
  .ctrl_lbe_i    (ctrl_lbe_i),
  .ctrl_out2_i   (ctrl_out2_i),
  .ctrl_out1_i   (ctrl_out1_i),
  .ctrl_dtr_i    (ctrl_dtr_i),
  .ctrl_rts_i    (ctrl_rts_i),
  .brk_i         (brk_i),
  .tx_wr_i       (tx_wr_i),
  .tx_data_i     (tx_data_i),
  .rx_full_i     (rx_full_i),
  .lb_active_o   (lb_active_o),
  .ms_flags_o    (ms_flags_o),
  .ms_irq_o      (ms_irq_o),
  .rx_push_o     (rx_push_o),
  .rx_push_data_o(rx_push_data_o)
);

// File: tb/uart_lb_path_bench.sv
module uart_lb_path_bench;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;
  localparam logic [8:0] BRK = 9'h100;

  // {lbe, out2, out1, dtr, rts, expected flags {ri,dcd,dsr,cts}}
  localparam logic [8:0] VEC [8] = '{
    {5'b11010, 4'b1010},
    {5'b01111, 4'b1010},
    {5'b10101, 4'b0101},
    {5'b11111, 4'b1111},
    {5'b10000, 4'b0000},
    {5'b01000, 4'b0000},
    {5'b10010, 4'b0010},
    {5'b11100, 4'b1100}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 0, ctrl_lbe = 0, ctrl_out2 = 0, ctrl_out1 = 0, ctrl_dtr = 0, ctrl_rts = 0;
  logic [3:0] irq_clr = '0;
  logic brk = 0, tx_wr = 0, ext_valid = 0, ext_brk = 0, full = 0;
  logic [DATA_W-1:0] tx_data = '0, ext_data = '0;
  logic lb_active, push;
  logic [3:0] flags, irq;
  logic [DATA_W:0] push_data;

  int checks = 0;
  int fails = 0;
  logic [3:0] exp_irq;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_lb_path #(.DATA_W(DATA_W)) u_uart_lb_path (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_wr_i(ctrl_wr), .ctrl_lbe_i(ctrl_lbe), .ctrl_out2_i(ctrl_out2),
    .ctrl_out1_i(ctrl_out1), .ctrl_dtr_i(ctrl_dtr), .ctrl_rts_i(ctrl_rts),
    .ms_irq_clr_i(irq_clr), .brk_i(brk), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .ext_rx_valid_i(ext_valid), .ext_rx_data_i(ext_data), .ext_brk_i(ext_brk),
    .rx_full_i(full), .lb_active_o(lb_active), .ms_flags_o(flags), .ms_irq_o(irq),
    .rx_push_o(push), .rx_push_data_o(push_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [4:0] c, input logic [3:0] clr);
    @(negedge clk);
    {ctrl_lbe, ctrl_out2, ctrl_out1, ctrl_dtr, ctrl_rts} = c;
    irq_clr = clr;
    ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    irq_clr = '0;
  endtask

  task automatic idle;
    tx_wr = 0; ext_valid = 0; ext_brk = 0; full = 0;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2 + 2);
    check("R3 reset lb", {15'd0, lb_active}, 16'd0);
    check("R1 reset flags", {12'd0, flags}, 16'd0);
    check("R4 reset irq", {12'd0, irq}, 16'd0);
    check("R10 reset push", {15'd0, push}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    exp_irq = '0;
    for (int i = 0; i < 8; i++) begin
      ctrl_write(VEC[i][8:4], 4'h0);
      if (VEC[i][8]) exp_irq = VEC[i][3:0];
      check(VEC[i][8] ? "R1 R2 flag map" : "R5 flags hold", {12'd0, flags}, {12'd0, VEC[i][3:0]});
      check(VEC[i][8] ? "R4 irq rebuild" : "R5 irq hold", {12'd0, irq}, {12'd0, exp_irq});
      check("R3 lb state", {15'd0, lb_active}, {15'd0, VEC[i][8]});
    end

    // loopback active, flags 1100
    @(negedge clk); tx_wr = 1; tx_data = 8'hC3; #1;
    check("R6 tx loop push", {15'd0, push}, 16'd1);
    check("R6 tx loop data", {7'd0, push_data}, 16'h0C3);
    @(negedge clk); idle(); ext_valid = 1; ext_data = 8'h5A; ext_brk = 1; #1;
    check("R8 ext ignored", {15'd0, push}, 16'd0);
    @(negedge clk); idle(); brk = 1; #1;
    check("R7 break push", {15'd0, push}, 16'd1);
    check("R7 break word", {7'd0, push_data}, {7'd0, BRK});
    @(negedge clk); #1;
    check("R7 held break", {15'd0, push}, 16'd0);
    @(negedge clk); brk = 0;
    @(negedge clk); brk = 1; tx_wr = 1; tx_data = 8'h77; #1;
    check("R7 break over tx", {7'd0, push_data}, {7'd0, BRK});
    @(negedge clk); brk = 0; tx_wr = 0;
    @(negedge clk); full = 1; tx_wr = 1; tx_data = 8'h21; #1;
    check("R10 full drop", {15'd0, push}, 16'd0);
    @(negedge clk); idle();

    // interrupt clear, then rebuild overriding a concurrent clear
    irq_clr = 4'hF;
    @(negedge clk); irq_clr = '0;
    check("R4 irq cleared", {12'd0, irq}, 16'd0);
    check("R4 flags kept", {12'd0, flags}, 16'hC);
    ctrl_write(5'b11100, 4'hF);
    check("R4 rebuild over clear", {12'd0, irq}, 16'hC);

    // leave loopback
    ctrl_write(5'b00011, 4'h0);
    check("R5 disable hold flags", {12'd0, flags}, 16'hC);
    check("R3 lb off", {15'd0, lb_active}, 16'd0);

    @(negedge clk); tx_wr = 1; tx_data = 8'h11; #1;
    check("R6 no tx push normal", {15'd0, push}, 16'd0);
    @(negedge clk); idle(); ext_valid = 1; ext_data = 8'h5A; #1;
    check("R9 ext char", {7'd0, push_data}, 16'h05A);
    check("R9 ext push", {15'd0, push}, 16'd1);
    @(negedge clk); ext_brk = 1; #1;
    check("R9 ext break wins", {7'd0, push_data}, {7'd0, BRK});
    @(negedge clk); idle(); ext_valid = 1; full = 1; #1;
    check("R10 full drop ext", {15'd0, push}, 16'd0);
    @(negedge clk); idle(); brk = 1; #1;
    check("R7 break off loop", {15'd0, push}, 16'd0);
    ctrl_write(5'b10000, 4'h0);
    #1;
    check("R7 no edge on enable", {15'd0, push}, 16'd0);
    check("R1 enable write maps", {12'd0, flags}, 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule